// File: doc/BRIEF.md
# Precision-Scalable Bit-Group Multiply-Accumulate Unit

This block multiplies unsigned activation and weight operands and accumulates the products into one running total. Every operand is cut into 2-bit slices, and a fixed grid of sixteen 2x2 multipliers computes all the slice products in parallel. A mode input decides how the grid is shared. In 8-bit mode the grid forms one 8x8 product. In 4-bit mode it forms four independent 4x4 products. In 2-bit mode it forms sixteen independent 2x2 products. Each slice product is shifted left by twice the sum of its activation-slice and weight-slice indices. An adder tree then sums all sixteen shifted terms into a single word.

The tree has one register stage, so a sum offered with valid in one cycle reaches the 32-bit accumulator at the next clock edge. A synchronous clear zeroes the accumulator. The accumulator acts as a small state machine with three actions: HOLD keeps the total, ADD adds the staged tree sum, and CLEAR loads zero. CLEAR is chosen whenever clear is high. ADD is chosen when a staged sum is pending and clear is low. HOLD is chosen in every other case. The mode may change from cycle to cycle, and each sample uses the mode present in its own cycle.

Top module: `prec_mac`

## Requirements
- R1: While reset is low, and after it is released, acc_o reads 0 until the first sum lands.
- R2: With mode_i = 0 (8-bit), a valid cycle adds act_i[7:0] * wgt_i[7:0].
- R3: With mode_i = 1 (4-bit), a valid cycle adds the sum over k = 0..3 of act_i[4k+3:4k] * wgt_i[4k+3:4k].
- R4: With mode_i = 2 (2-bit), a valid cycle adds the sum over k = 0..15 of act_i[2k+1:2k] * wgt_i[2k+1:2k].
- R5: mode_i = 3 behaves exactly like the 2-bit mode.
- R6: Operand bits above the active width are ignored: bits 31:8 in 8-bit mode and bits 31:16 in 4-bit mode.
- R7: A sum sampled with vld_i at edge k appears on acc_o after edge k+1, and not after edge k.
- R8: clr_i high at an edge makes acc_o 0 after that edge.
- R9: If clr_i is high at the edge where a staged sum would land (vld_i was high one cycle earlier), that sum is discarded and acc_o is 0.
- R10: A sample taken with vld_i and clr_i both high lands on the zeroed total at the following edge.
- R11: With vld_i low in the previous cycle and clr_i low, acc_o holds its value.
- R12: The accumulator wraps modulo 2^32.
- R13: mode_i may change on every cycle, and each sample is computed in its own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Precision select: 0 = 8-bit, 1 = 4-bit, 2 or 3 = 2-bit |
| act_i | input | 32 | Packed activation operands |
| wgt_i | input | 32 | Packed weight operands |
| vld_i | input | 1 | Operands valid this cycle |
| clr_i | input | 1 | Synchronous accumulator clear |
| acc_o | output | 32 | Accumulated total |

## Verification
Two functions can act on the accumulator at the same edge: CLEAR, and the ADD of a sum that was staged in the previous cycle. To provoke this, the bench raises vld_i in one cycle and clr_i in the next. The result is judged correct only if acc_o reads zero and the staged sum is absent. The bench also raises clr_i and vld_i in the same cycle, and then checks that the fresh sum lands alone on the zeroed total one edge later.

// File: rtl/bgm_pkg.sv
package bgm_pkg;
    localparam int SLICE_W = 2;

    typedef enum logic [1:0] {
        PREC_8  = 2'd0,
        PREC_4  = 2'd1,
        PREC_2  = 2'd2,
        PREC_2X = 2'd3
    } prec_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_ADD,
        ACT_CLEAR
    } acc_act_e;
endpackage

// File: rtl/bgm_route.sv
module bgm_route
    import bgm_pkg::*;
#(
    parameter int GRID = 4,
    parameter int UIDX = 0,
    parameter int SH_W = 4
) (
    input  prec_e                              mode_i,
    input  logic [GRID*GRID*SLICE_W-1:0]       act_i,
    input  logic [GRID*GRID*SLICE_W-1:0]       wgt_i,
    output logic [SLICE_W-1:0]                 a_sl_o,
    output logic [SLICE_W-1:0]                 w_sl_o,
    output logic [SH_W-1:0]                    sh_o
);
    localparam int HALF = GRID / 2;
    localparam int SUB  = HALF * HALF;
    // full-width placement
    localparam int F_I  = UIDX / GRID;
    localparam int F_J  = UIDX % GRID;
    localparam int A8   = F_I * SLICE_W;
    localparam int W8   = F_J * SLICE_W;
    localparam int SH8  = (F_I + F_J) * SLICE_W;
    // half-width placement
    localparam int H_K  = UIDX / SUB;
    localparam int H_I  = (UIDX % SUB) / HALF;
    localparam int H_J  = UIDX % HALF;
    localparam int A4   = (H_K * HALF + H_I) * SLICE_W;
    localparam int W4   = (H_K * HALF + H_J) * SLICE_W;
    localparam int SH4  = (H_I + H_J) * SLICE_W;
    // slice-width placement
    localparam int A2   = UIDX * SLICE_W;

    always_comb begin
        unique case (mode_i)
            PREC_8: begin
                a_sl_o = act_i[A8 +: SLICE_W];
                w_sl_o = wgt_i[W8 +: SLICE_W];
                sh_o   = SH_W'(SH8);
            end
            PREC_4: begin
                a_sl_o = act_i[A4 +: SLICE_W];
                w_sl_o = wgt_i[W4 +: SLICE_W];
                sh_o   = SH_W'(SH4);
            end
            PREC_2, PREC_2X: begin
                a_sl_o = act_i[A2 +: SLICE_W];
                w_sl_o = wgt_i[A2 +: SLICE_W];
                sh_o   = '0;
            end
        endcase
    end
endmodule

// File: rtl/bgm_mul2.sv
module bgm_mul2 #(
    parameter int SW = 2
) (
    input  logic [SW-1:0]   a_i,
    input  logic [SW-1:0]   b_i,
    output logic [2*SW-1:0] p_o
);
    assign p_o = {{SW{1'b0}}, a_i} * {{SW{1'b0}}, b_i};
endmodule

// File: rtl/bgm_tree.sv
module bgm_tree #(
    parameter int UNITS = 16,
    parameter int PW    = 4,
    parameter int SH_W  = 4,
    parameter int SUM_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       vld_i,
    input  logic [UNITS-1:0][PW-1:0]   prod_i,
    input  logic [UNITS-1:0][SH_W-1:0] sh_i,
    output logic [SUM_W-1:0]           sum_o,
    output logic                       vld_o
);
    logic [SUM_W-1:0] sum_d;

    always_comb begin
        sum_d = '0;
        for (int u = 0; u < UNITS; u++) begin
            sum_d = sum_d + (SUM_W'(prod_i[u]) << sh_i[u]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o <= '0;
            vld_o <= 1'b0;
        end else begin
            vld_o <= vld_i;
            if (vld_i) sum_o <= sum_d;
        end
    end
endmodule

// File: rtl/bgm_acc.sv
module bgm_acc
    import bgm_pkg::*;
#(
    parameter int SUM_W = 16,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             add_vld_i,
    input  logic [SUM_W-1:0] add_i,
    output logic [ACC_W-1:0] acc_o
);
    acc_act_e         act;
    logic [ACC_W-1:0] acc_d;

    always_comb begin
        if (clr_i)          act = ACT_CLEAR;
        else if (add_vld_i) act = ACT_ADD;
        else                act = ACT_HOLD;
    end

    always_comb begin
        unique case (act)
            ACT_CLEAR: acc_d = '0;
            ACT_ADD:   acc_d = acc_o + ACC_W'(add_i);
            default:   acc_d = acc_o;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_o <= '0;
        else        acc_o <= acc_d;
    end
endmodule

// File: rtl/prec_mac.sv
module prec_mac
    import bgm_pkg::*;
#(
    parameter int GRID  = 4,
    parameter int ACC_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [1:0]                    mode_i,
    input  logic [GRID*GRID*SLICE_W-1:0]  act_i,
    input  logic [GRID*GRID*SLICE_W-1:0]  wgt_i,
    input  logic                          vld_i,
    input  logic                          clr_i,
    output logic [ACC_W-1:0]              acc_o
);
    localparam int UNITS = GRID * GRID;
    localparam int PW    = 2 * SLICE_W;
    localparam int SH_W  = $clog2(2 * (GRID - 1) * SLICE_W + 1);
    localparam int SUM_W = 2 * GRID * SLICE_W;

    prec_e                       mode;
    logic [UNITS-1:0][PW-1:0]    prod;
    logic [UNITS-1:0][SH_W-1:0]  sh;
    logic [SUM_W-1:0]            tree_sum;
    logic                        tree_vld;

    assign mode = prec_e'(mode_i);

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        logic [SLICE_W-1:0] a_sl;
        logic [SLICE_W-1:0] w_sl;

        bgm_route #(.GRID(GRID), .UIDX(u), .SH_W(SH_W)) i_route (
            .mode_i (mode),
            .act_i  (act_i),
            .wgt_i  (wgt_i),
            .a_sl_o (a_sl),
            .w_sl_o (w_sl),
            .sh_o   (sh[u])
        );

        bgm_mul2 #(.SW(SLICE_W)) i_mul (
            .a_i (a_sl),
            .b_i (w_sl),
            .p_o (prod[u])
        );
    end

    bgm_tree #(.UNITS(UNITS), .PW(PW), .SH_W(SH_W), .SUM_W(SUM_W)) i_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (vld_i),
        .prod_i (prod),
        .sh_i   (sh),
        .sum_o  (tree_sum),
        .vld_o  (tree_vld)
    );

    bgm_acc #(.SUM_W(SUM_W), .ACC_W(ACC_W)) i_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr_i),
        .add_vld_i (tree_vld),
        .add_i     (tree_sum),
        .acc_o     (acc_o)
    );
endmodule

// File: rtl/prec_mac_chk.sv
module prec_mac_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic             vld_i,
    input logic             clr_i,
    input logic [ACC_W-1:0] acc_o
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> acc_o == '0);

    // R8
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> acc_o == '0);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i ##1 !clr_i) |=> $stable(acc_o));

    // R2
    eight_bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_i && mode_i == 2'd0) ##1 !clr_i) |=> (acc_o - $past(acc_o)) <= ACC_W'(65025));

    // R3
    four_bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_i && mode_i == 2'd1) ##1 !clr_i) |=> (acc_o - $past(acc_o)) <= ACC_W'(900));

    // R4
    two_bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_i && mode_i[1]) ##1 !clr_i) |=> (acc_o - $past(acc_o)) <= ACC_W'(144));
endmodule

bind prec_mac prec_mac_chk #(.ACC_W(ACC_W)) i_prec_mac_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .vld_i  (vld_i),
    .clr_i  (clr_i),
    .acc_o  (acc_o)
);

// File: tb/test_prec_mac.sv
module test_prec_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = '0;
    logic [31:0] act_i = '0;
    logic [31:0] wgt_i = '0;
    logic        vld_i = 1'b0;
    logic        clr_i = 1'b0;
    logic [31:0] acc_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] model_acc = '0;
    logic        pend_v = 1'b0;
    logic [31:0] pend_s = '0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    prec_mac i_prec_mac (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .act_i(act_i),
        .wgt_i(wgt_i), .vld_i(vld_i), .clr_i(clr_i), .acc_o(acc_o)
    );

    function automatic logic [31:0] ref_sum(logic [1:0] m, logic [31:0] a, logic [31:0] w);
        logic [31:0] s = '0;
        if (m == 2'd0) begin
            s = 32'(a[7:0]) * 32'(w[7:0]);
        end else if (m == 2'd1) begin
            for (int k = 0; k < 4; k++) s += 32'(a[4*k +: 4]) * 32'(w[4*k +: 4]);
        end else begin
            for (int k = 0; k < 16; k++) s += 32'(a[2*k +: 2]) * 32'(w[2*k +: 2]);
        end
        return s;
    endfunction

    task automatic step(logic [1:0] m, logic [31:0] a, logic [31:0] w,
                        logic v, logic c, string tag);
        @(negedge clk);
        mode_i = m; act_i = a; wgt_i = w; vld_i = v; clr_i = c;
        @(posedge clk);
        if (c)           model_acc = '0;
        else if (pend_v) model_acc = model_acc + pend_s;
        pend_v = v;
        pend_s = ref_sum(m, a, w);
        exp_q.push_back(model_acc);
        tag_q.push_back(tag);
    endtask

    task automatic idle(string tag);
        step(2'd0, '0, '0, 1'b0, 1'b0, tag);
    endtask

    // monitor: compare design output with scoreboard entries
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (acc_o !== e) begin
                    errors++;
                    $display("FAIL %s: acc_o=%0d expected %0d", t, acc_o, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset state before release
        @(negedge clk);
        checks++;
        if (acc_o !== 32'd0) begin
            errors++;
            $display("FAIL R1: acc_o=%0d expected 0", acc_o);
        end
        rst_n = 1'b1;
        idle("R1");
        idle("R1");

        // R2 8-bit mode and R7 latency
        step(2'd0, 32'd255, 32'd255, 1'b1, 1'b0, "R7");
        idle("R2");
        step(2'd0, 32'd17, 32'd3, 1'b1, 1'b0, "R2");
        idle("R2");
        // R6 upper bits ignored in 8-bit mode
        step(2'd0, 32'hABCD_EF05, 32'h1234_5607, 1'b1, 1'b0, "R6");
        idle("R6");
        // R8 clear
        step(2'd0, '0, '0, 1'b0, 1'b1, "R8");
        idle("R8");
        // R3 4-bit mode
        step(2'd1, 32'h0000_FFFF, 32'h0000_FFFF, 1'b1, 1'b0, "R3");
        step(2'd1, 32'h0000_1234, 32'h0000_5678, 1'b1, 1'b0, "R3");
        idle("R3");
        // R6 upper bits ignored in 4-bit mode
        step(2'd1, 32'hFFFF_9A3C, 32'h5555_2E71, 1'b1, 1'b0, "R6");
        idle("R6");
        // R4 2-bit mode
        step(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0, "R4");
        step(2'd2, 32'h1B2C_3D4E, 32'hE4D3_C2B1, 1'b1, 1'b0, "R4");
        idle("R4");
        // R5 code 3 same as 2-bit
        step(2'd3, 32'h9876_5432, 32'h0F1E_2D3C, 1'b1, 1'b0, "R5");
        idle("R5");
        // R11 hold over several idle cycles
        idle("R11");
        idle("R11");
        idle("R11");
        // R9 clear collides with landing sum
        step(2'd0, 32'd200, 32'd100, 1'b1, 1'b0, "R9");
        step(2'd0, '0, '0, 1'b0, 1'b1, "R9");
        idle("R9");
        // R10 clear together with valid
        step(2'd0, 32'd50, 32'd60, 1'b1, 1'b0, "R10");
        step(2'd1, 32'h0000_7777, 32'h0000_3333, 1'b1, 1'b1, "R10");
        idle("R10");
        // R13 mode changes every cycle
        for (int i = 0; i < 40; i++) begin
            step(2'(i % 4), $urandom, $urandom, 1'b1, 1'(i % 11 == 10), "R13");
        end
        idle("R13");
        // R12 wrap modulo 2^32
        step(2'd0, '0, '0, 1'b0, 1'b1, "R12");
        for (int i = 0; i < 66100; i++) begin
            step(2'd0, 32'd255, 32'd255, 1'b1, 1'b0, "R12");
        end
        idle("R12");
        idle("R12");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule